// File: doc/BRIEF.md
# Card Identification EEPROM Mailbox

This block sits on a simple 16-bit register bus and gives a host processor access to the identification EEPROMs of up to three plug-in interface cards. The host picks a card by writing a select code into the slot register. The slot register is shared with a presence readback. A read of that register shows, active low, which cards are fitted.

To read an EEPROM, the host writes two command words into the command register. The first word holds the read opcode with a 6-bit byte offset in its low bits. The second word is zero. The second write arms a one-shot valid flag. The next read of the command register returns two adjacent EEPROM bytes packed into one word and clears the flag. When no slot is selected, or the selected card is missing, the read returns all ones, which is what an empty EEPROM gives. Each card's EEPROM is a 64-byte array inside the block. A preload port fills it.

Top module: `card_id_mailbox`

## Requirements
- R1: After reset, the select register holds no valid code, the command position is zero and the valid flag is clear, so a read of the command register returns 0xFFFF.
- R2: A read of the slot register returns 0xFFFF with bit k (k = 0..2) cleared when `card_present[k]` is 1.
- R3: A write to the slot register stores the 16-bit value. The code 0x1700 selects slot 0, 0x1D00 selects slot 1 and 0x3500 selects slot 2. Any other value selects no slot, and a command read then returns 0xFFFF.
- R4: Command register writes alternate between first and second word. Only the second write sets the valid flag, so a read after a single write returns 0xFFFF.
- R5: A read of the command register with the flag set returns the byte at offset o in bits 15:8 and the byte at o+1 in bits 7:0. The offset o is bits 5:0 of the first command word.
- R6: A command read clears the valid flag. A further read without a new command returns 0xFFFF.
- R7: The second byte address wraps modulo 64, so offset 63 pairs byte 63 with byte 0.
- R8: A valid read when the selected slot has `card_present` low returns 0xFFFF and still clears the flag.
- R9: A new two-word command written while an earlier one is still pending replaces it. Only the newer offset is read.
- R10: Read data appears on `bus_rdata` at the clock edge that samples `bus_rd`. It holds until the next read. Reads of unmapped addresses return 0x0000.
- R11: Bits 15:6 of the first command word do not change the returned data.
- R12: A preload write stores `pl_data` at `pl_addr` of slot `pl_slot`. Later command reads return that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| card_present | input | 3 | Per-slot card fitted, active high |
| pl_we | input | 1 | EEPROM preload write enable |
| pl_slot | input | 2 | Preload target slot |
| pl_addr | input | 6 | Preload byte address |
| pl_data | input | 8 | Preload byte |

## Verification
On every cycle the assertions check the presence readback, the all-ones answer with no pending command, the all-ones answer for an unselected or empty slot, and that the valid flag only rises after a command write and falls after a command read. The byte pairing, the wrap at offset 63, the select codes, the command overwrite and the masking of upper offset bits need the preloaded contents. Only the bench scenarios can show these, by comparing against its own model of the EEPROM arrays.

// File: rtl/card_mbox_pkg.sv
package card_mbox_pkg;

  localparam int DATA_W    = 16;
  localparam int MAX_SLOTS = 3;

  // select codes, slot k in bits [16k +: 16]
  localparam logic [MAX_SLOTS*DATA_W-1:0] SLOT_CODES =
    {16'h3500, 16'h1D00, 16'h1700};

  localparam logic [DATA_W-1:0] ALL_ONES = '1;

endpackage

// File: rtl/mbox_sel_decode.sv
module mbox_sel_decode
  import card_mbox_pkg::*;
#(
  parameter int NUM_SLOTS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [DATA_W-1:0]    wdata,
  output logic [NUM_SLOTS-1:0] hit
);

  logic [DATA_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst)     sel_q <= '0;
    else if (we) sel_q <= wdata;
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_cmp
    assign hit[k] = (sel_q == SLOT_CODES[k*DATA_W +: DATA_W]);
  end

endmodule

// File: rtl/mbox_cmd_buf.sv
module mbox_cmd_buf #(
  parameter int OFS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [OFS_W-1:0] wofs,
  output logic [OFS_W-1:0] ofs,
  output logic             valid
);

  logic pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= 1'b0;
      ofs   <= '0;
      valid <= 1'b0;
    end else begin
      if (wr) begin
        pos_q <= ~pos_q;
        if (!pos_q) ofs <= wofs;
      end
      if (wr && pos_q)  valid <= 1'b1;
      else if (rd)      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/mbox_id_store.sv
module mbox_id_store #(
  parameter int OFS_W = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [OFS_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [OFS_W-1:0] raddr,
  output logic [7:0]       rd_hi,
  output logic [7:0]       rd_lo
);

  localparam int DEPTH = 1 << OFS_W;

  logic [7:0]       mem [DEPTH];
  logic [OFS_W-1:0] raddr_nx;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign raddr_nx = raddr + 1'b1;
  assign rd_hi    = mem[raddr];
  assign rd_lo    = mem[raddr_nx];

endmodule

// File: rtl/card_id_mailbox.sv
module card_id_mailbox
  import card_mbox_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          NUM_SLOTS = 3,
  parameter int          OFS_W     = 6,
  parameter logic [7:0]  SEL_REG   = 8'h10,
  parameter logic [7:0]  CMD_REG   = 8'h20,
  localparam int         SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_SLOTS-1:0] card_present,
  input  logic                 pl_we,
  input  logic [SLOT_W-1:0]    pl_slot,
  input  logic [OFS_W-1:0]     pl_addr,
  input  logic [7:0]           pl_data
);

  logic                 sel_we, cmd_wr, cmd_rd;
  logic [NUM_SLOTS-1:0] sel_hit;
  logic [OFS_W-1:0]     cmd_ofs;
  logic                 cmd_valid;
  logic [7:0]           hi_b [NUM_SLOTS];
  logic [7:0]           lo_b [NUM_SLOTS];
  logic [DATA_W-1:0]    pair_word;
  logic                 pair_ok;
  logic [DATA_W-1:0]    rdata_nx;

  assign sel_we = bus_wr && (bus_addr == SEL_REG[ADDR_W-1:0]);
  assign cmd_wr = bus_wr && (bus_addr == CMD_REG[ADDR_W-1:0]);
  assign cmd_rd = bus_rd && (bus_addr == CMD_REG[ADDR_W-1:0]);

  mbox_sel_decode #(.NUM_SLOTS(NUM_SLOTS)) u_sel (
    .clk(clk), .rst(rst), .we(sel_we), .wdata(bus_wdata), .hit(sel_hit)
  );

  mbox_cmd_buf #(.OFS_W(OFS_W)) u_cmd (
    .clk(clk), .rst(rst), .wr(cmd_wr), .rd(cmd_rd),
    .wofs(bus_wdata[OFS_W-1:0]), .ofs(cmd_ofs), .valid(cmd_valid)
  );

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    mbox_id_store #(.OFS_W(OFS_W)) u_store (
      .clk(clk),
      .we(pl_we && (pl_slot == SLOT_W'(k))),
      .waddr(pl_addr), .wdata(pl_data),
      .raddr(cmd_ofs), .rd_hi(hi_b[k]), .rd_lo(lo_b[k])
    );
  end

  always_comb begin
    pair_word = '0;
    pair_ok   = 1'b0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (sel_hit[k] && card_present[k]) begin
        pair_word = pair_word | {hi_b[k], lo_b[k]};
        pair_ok   = 1'b1;
      end
    end
  end

  always_comb begin
    rdata_nx = '0;
    if (bus_addr == SEL_REG[ADDR_W-1:0])
      rdata_nx = {{(DATA_W-NUM_SLOTS){1'b1}}, ~card_present};
    else if (bus_addr == CMD_REG[ADDR_W-1:0])
      rdata_nx = (cmd_valid && pair_ok) ? pair_word : ALL_ONES;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rdata_nx;
  end

endmodule

// File: rtl/card_id_mailbox_chk.sv
module card_id_mailbox_chk #(
  parameter int         ADDR_W    = 8,
  parameter int         NUM_SLOTS = 3,
  parameter logic [7:0] SEL_REG   = 8'h10,
  parameter logic [7:0] CMD_REG   = 8'h20
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [15:0]          bus_rdata,
  input logic [NUM_SLOTS-1:0] card_present,
  input logic [NUM_SLOTS-1:0] sel_hit,
  input logic                 cmd_valid
);

  logic at_sel, at_cmd;
  assign at_sel = (bus_addr == SEL_REG[ADDR_W-1:0]);
  assign at_cmd = (bus_addr == CMD_REG[ADDR_W-1:0]);

  // R2
  presence_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && at_sel) |=> bus_rdata == {{(16-NUM_SLOTS){1'b1}}, ~$past(card_present)});

  // R6
  idle_read_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && at_cmd && !cmd_valid) |=> bus_rdata == 16'hFFFF);

  // R8
  empty_slot_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && at_cmd && ((sel_hit & card_present) == '0)) |=> bus_rdata == 16'hFFFF);

  // R6
  valid_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && at_cmd && !bus_wr) |=> !cmd_valid);

  // R4
  valid_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_valid) |-> $past(bus_wr && at_cmd));

endmodule

bind card_id_mailbox card_id_mailbox_chk #(
  .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .SEL_REG(SEL_REG), .CMD_REG(CMD_REG)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .card_present(card_present), .sel_hit(sel_hit),
  .cmd_valid(cmd_valid)
);

// File: tb/card_id_mailbox_tb.sv
`timescale 1ns/1ps
module card_id_mailbox_tb;

  localparam logic [7:0] SEL_A = 8'h10;
  localparam logic [7:0] CMD_A = 8'h20;

  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  card_present = '0;
  logic        pl_we = 0;
  logic [1:0]  pl_slot = '0;
  logic [5:0]  pl_addr = '0;
  logic [7:0]  pl_data = '0;

  int errs = 0, checks = 0, cyc = 0;

  logic [7:0]  model [3][64];
  logic [15:0] m_sel = '0;
  logic        m_pos = 0, m_valid = 0;
  logic [5:0]  m_ofs = '0;

  always #10 clk = ~clk;

  card_id_mailbox u_dut (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    if (a == SEL_A) m_sel = d;
    if (a == CMD_A) begin
      if (!m_pos) m_ofs = d[5:0];
      else        m_valid = 1;
      m_pos = ~m_pos;
    end
  endtask

  task automatic brd(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
    d = bus_rdata;  // R10: valid right after the sampling edge
  endtask

  function automatic int slot_of(input logic [15:0] s);
    case (s)
      16'h1700: return 0;
      16'h1D00: return 1;
      16'h3500: return 2;
      default:  return -1;
    endcase
  endfunction

  function automatic logic [15:0] exp_cmd();
    int s = slot_of(m_sel);
    if (!m_valid || s < 0) return 16'hFFFF;
    if (!card_present[s]) return 16'hFFFF;
    return {model[s][m_ofs], model[s][6'(m_ofs + 1)]};
  endfunction

  task automatic cmd_read(input string tag);
    logic [15:0] d, e;
    e = exp_cmd();
    brd(CMD_A, d);
    m_valid = 0;
    chk(tag, d, e);
  endtask

  task automatic issue(input logic [15:0] w0);
    bwr(CMD_A, w0);
    bwr(CMD_A, 16'h0000);
  endtask

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5EED));
    @(negedge clk); @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 rdata after reset", bus_rdata, 16'h0000);
    cmd_read("R1 idle cmd read");
    card_present = 3'b000;
    brd(SEL_A, d); chk("R2 none present", d, 16'hFFFF);

    // R12 preload
    for (int s = 0; s < 3; s++)
      for (int a = 0; a < 64; a++) begin
        model[s][a] = 8'($urandom);
        pl_we = 1; pl_slot = 2'(s); pl_addr = 6'(a); pl_data = model[s][a];
        @(negedge clk);
      end
    pl_we = 0;

    card_present = 3'b101;
    brd(SEL_A, d); chk("R2 slots 0,2 present", d, 16'hFFFA);
    card_present = 3'b111;
    brd(SEL_A, d); chk("R2 all present", d, 16'hFFF8);

    // R3 each code, R5/R12 content
    bwr(SEL_A, 16'h1700); issue(16'h0180 | 16'd4);  cmd_read("R3 slot0 code R5");
    bwr(SEL_A, 16'h1D00); issue(16'h0180 | 16'd10); cmd_read("R3 slot1 code R12");
    bwr(SEL_A, 16'h3500); issue(16'h0180 | 16'd33); cmd_read("R3 slot2 code R5");
    bwr(SEL_A, 16'h1701); issue(16'h0180);          cmd_read("R3 bad code");

    // R4 single write then read
    bwr(SEL_A, 16'h1700);
    bwr(CMD_A, 16'h0180 | 16'd7);
    cmd_read("R4 one word only");
    bwr(CMD_A, 16'h0000);
    cmd_read("R4 second word arms");
    // R6 repeat read
    cmd_read("R6 second read");
    // R7 wrap
    issue(16'h0180 | 16'd63); cmd_read("R7 offset 63 wrap");
    // R8 absent card
    card_present = 3'b110;
    issue(16'h0180 | 16'd2); cmd_read("R8 absent slot");
    cmd_read("R8 flag cleared");
    card_present = 3'b111;
    // R9 overwrite
    issue(16'h0180 | 16'd5); issue(16'h0180 | 16'd40); cmd_read("R9 newer command");
    // R11 upper bits ignored
    issue(16'hFFC0 | 16'd12); cmd_read("R11 upper bits");
    // R10 unmapped and hold
    brd(8'h33, d); chk("R10 unmapped read", d, 16'h0000);
    @(negedge clk); chk("R10 hold", bus_rdata, 16'h0000);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0: begin
          int c = $urandom_range(0, 3);
          bwr(SEL_A, c == 0 ? 16'h1700 : c == 1 ? 16'h1D00 : c == 2 ? 16'h3500 : 16'($urandom));
        end
        1, 2: bwr(CMD_A, 16'($urandom));
        3: cmd_read("R5 random read");
        4: begin brd(SEL_A, d); chk("R2 random", d, {13'h1FFF, ~card_present}); end
        default: card_present = 3'($urandom);
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule